// File: doc/BRIEF.md
# Partitionable Packed SIMD ALU

This unit treats each of its two 64-bit register operands as a packed vector. A lane-size field splits the vector into eight 8-bit, four 16-bit or two 32-bit lanes. It applies one operation to every lane at once. The unit never touches memory; both operands come straight from registers.

Additions and subtractions share one byte-sliced carry chain. The carry is cut wherever a lane begins, and each lane saturates on its own. Four signed 16x16 multipliers supply the low-half, high-half and multiply-add results. The selected result is registered, and a valid flag follows it with the same one-cycle latency. When the opcode and lane size do not form a supported pair, the unit returns zero and raises an error flag.

Top module: `simd_alu_top`

## Requirements
- R1: A result, its error flag and `out_valid` are registered one cycle after an input is accepted with `in_valid` high. A cycle with `in_valid` low gives `out_valid` low in the next cycle, and `out_result` and `out_err` keep their last values.
- R2: Opcode 0 is wrap-around add. Each lane is the sum of its operand lanes modulo 2^lane width, and no carry crosses a lane boundary. The lane size encoding is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit lanes; encoding 3 is reserved.
- R3: Opcode 1 is unsigned saturating add. A lane whose sum overflows becomes all ones.
- R4: Opcode 2 is wrap-around subtract, a minus b, modulo 2^lane width per lane. No borrow crosses a lane boundary.
- R5: Opcode 3 is unsigned saturating subtract. A lane where b exceeds a becomes zero.
- R6: Opcode 4 gives the low 16 bits, and opcode 5 the high 16 bits, of the signed 16x16 product in each 16-bit lane. Both are valid only with lane size 1.
- R7: Opcode 6, valid only with lane size 1, gives two 32-bit lanes. Each lane is the sum, modulo 2^32, of the two signed products of the adjacent 16-bit lanes below it.
- R8: Opcode 7 is bitwise AND and opcode 8 is bitwise OR of the whole operands. They accept lane sizes 0, 1 and 2.
- R9: Opcodes 9 to 15, lane size 3, and multiply opcodes 4 to 6 with a lane size other than 1 all give a zero result with `out_err` set. Every supported pair gives `out_err` clear.
- R10: While `rst_n` is low, `out_valid`, `out_result` and `out_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; operands and controls are taken when high |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Lane size code |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result valid, one cycle after an accepted input |
| out_result | output | 64 | Registered packed result |
| out_err | output | 1 | Unsupported opcode and lane size pair |

## Verification
Every result, its error flag and its valid flag are due exactly one rising edge after the input is taken. The bench drives an input on a falling edge and lowers `in_valid` on the next falling edge. It compares the outputs at that same second falling edge, which is half a cycle after the capturing edge. A further idle falling edge then confirms that `out_valid` has dropped and that the result has held. The sweep covers every opcode with every lane size, using corner operands and pseudo-random operands. Expected lanes are recomputed in the bench with plain integer arithmetic.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DW     = 64;
  localparam int BYTE_W = 8;
  localparam int NBYTE  = DW / BYTE_W;
  localparam int MUL_W  = 16;
  localparam int NMUL   = DW / MUL_W;
  localparam int OP_W   = 4;
  localparam int SZ_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_ADDS  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBS  = 4'd3,
    OP_MULLO = 4'd4,
    OP_MULHI = 4'd5,
    OP_MADD  = 4'd6,
    OP_AND   = 4'd7,
    OP_OR    = 4'd8
  } op_e;

  localparam logic [SZ_W-1:0] SZ_8  = 2'd0;
  localparam logic [SZ_W-1:0] SZ_16 = 2'd1;
  localparam logic [SZ_W-1:0] SZ_32 = 2'd2;

  // true when byte k is the lowest byte of its lane
  function automatic logic lane_start(input int k, input logic [SZ_W-1:0] sz);
    return (k & ((1 << int'(sz)) - 1)) == 0;
  endfunction

  // index of the highest byte of the lane holding byte k
  function automatic int lane_top(input int k, input logic [SZ_W-1:0] sz);
    return k | ((1 << int'(sz)) - 1);
  endfunction

  function automatic logic signed [2*MUL_W-1:0] smul(input logic [MUL_W-1:0] x,
                                                      input logic [MUL_W-1:0] y);
    return $signed(x) * $signed(y);
  endfunction
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
(
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            sub,
  input  logic            sat,
  input  logic [SZ_W-1:0] size,
  output logic [DW-1:0]   y
);
  logic [NBYTE-1:0]  byte_cin;
  logic [NBYTE-1:0]  byte_cout;
  logic [DW-1:0]     raw_sum;

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    logic [BYTE_W-1:0] bop;
    assign bop = sub ? ~b[k*BYTE_W +: BYTE_W] : b[k*BYTE_W +: BYTE_W];
    if (k == 0) begin : g_first
      assign byte_cin[k] = sub;
    end else begin : g_rest
      // lane boundary: drop the lower carry, inject the subtract one
      assign byte_cin[k] = lane_start(k, size) ? sub : byte_cout[k-1];
    end
    assign {byte_cout[k], raw_sum[k*BYTE_W +: BYTE_W]} =
      {1'b0, a[k*BYTE_W +: BYTE_W]} + {1'b0, bop} + {{BYTE_W{1'b0}}, byte_cin[k]};
  end

  always_comb begin
    for (int k = 0; k < NBYTE; k++) begin
      logic lc;
      lc = byte_cout[lane_top(k, size)];
      if (sat && (sub ? !lc : lc))
        y[k*BYTE_W +: BYTE_W] = sub ? '0 : '1;
      else
        y[k*BYTE_W +: BYTE_W] = raw_sum[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/simd_mul.sv
module simd_mul
  import simd_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi,
  output logic [DW-1:0] madd
);
  localparam int PW = 2 * MUL_W;
  logic signed [PW-1:0] prod [NMUL];

  for (genvar j = 0; j < NMUL; j++) begin : g_lane
    assign prod[j] = smul(a[j*MUL_W +: MUL_W], b[j*MUL_W +: MUL_W]);
    assign lo[j*MUL_W +: MUL_W] = prod[j][MUL_W-1:0];
    assign hi[j*MUL_W +: MUL_W] = prod[j][PW-1:MUL_W];
  end

  for (genvar p = 0; p < NMUL/2; p++) begin : g_pair
    assign madd[p*PW +: PW] = prod[2*p] + prod[2*p+1];
  end
endmodule

// File: rtl/simd_alu_top.sv
module simd_alu_top
  import simd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic [SZ_W-1:0] in_size,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  output logic            out_valid,
  output logic [DW-1:0]   out_result,
  output logic            out_err
);
  logic [DW-1:0] as_y, mul_lo, mul_hi, mul_madd;
  logic [DW-1:0] alu_y;
  logic          as_sub, as_sat, supported, size_ok;

  assign as_sub  = (in_op == OP_SUB)  || (in_op == OP_SUBS);
  assign as_sat  = (in_op == OP_ADDS) || (in_op == OP_SUBS);
  assign size_ok = (in_size != 2'd3);

  simd_addsub u_addsub (
    .a(in_a), .b(in_b), .sub(as_sub), .sat(as_sat), .size(in_size), .y(as_y)
  );

  simd_mul u_mul (
    .a(in_a), .b(in_b), .lo(mul_lo), .hi(mul_hi), .madd(mul_madd)
  );

  always_comb begin
    supported = 1'b0;
    alu_y     = '0;
    case (in_op)
      OP_ADD, OP_ADDS, OP_SUB, OP_SUBS: begin supported = size_ok; alu_y = as_y; end
      OP_MULLO: begin supported = (in_size == SZ_16); alu_y = mul_lo;   end
      OP_MULHI: begin supported = (in_size == SZ_16); alu_y = mul_hi;   end
      OP_MADD:  begin supported = (in_size == SZ_16); alu_y = mul_madd; end
      OP_AND:   begin supported = size_ok; alu_y = in_a & in_b; end
      OP_OR:    begin supported = size_ok; alu_y = in_a | in_b; end
      default:  begin supported = 1'b0; alu_y = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= supported ? alu_y : '0;
        out_err    <= !supported;
      end
    end
  end

  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_err));

  p_sat_add_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == OP_ADDS && in_size == SZ_8 |=> out_result[7:0] >= $past(in_a[7:0]));

  p_sat_sub_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == OP_SUBS && in_size == SZ_8 |=> out_result[7:0] <= $past(in_a[7:0]));

  p_and_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == OP_AND && in_size != 2'd3 |=> (out_result & ~$past(in_a)) == '0);

  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_result == '0);
endmodule

// File: tb/simd_alu_top_tb.sv
module simd_alu_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid, out_err;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_alu_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
    .out_err(out_err)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // expected {err, result} from the requirements
  function automatic logic [64:0] model(input int op, input int sz,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] res, mask, x, y, r;
    int w;
    bit ok;
    res = '0;
    ok = (sz != 3) && ((op <= 3) || op == 7 || op == 8 || (op >= 4 && op <= 6 && sz == 1));
    if (!ok) return {1'b1, 64'd0};
    w = 8 << sz;
    mask = (64'd1 << w) - 64'd1;
    if (op == 6) begin
      for (int p = 0; p < 2; p++) begin
        int p0, p1;
        logic [31:0] s;
        p0 = int'(shortint'(a[p*32 +: 16])) * int'(shortint'(b[p*32 +: 16]));
        p1 = int'(shortint'(a[p*32+16 +: 16])) * int'(shortint'(b[p*32+16 +: 16]));
        s = 32'(p0 + p1);
        res[p*32 +: 32] = s;
      end
      return {1'b0, res};
    end
    for (int l = 0; l < 64 / w; l++) begin
      int prod;
      x = (a >> (l*w)) & mask;
      y = (b >> (l*w)) & mask;
      prod = int'(shortint'(x[15:0])) * int'(shortint'(y[15:0]));
      case (op)
        0: r = (x + y) & mask;
        1: r = (x + y > mask) ? mask : x + y;
        2: r = (x - y) & mask;
        3: r = (x < y) ? 64'd0 : x - y;
        4: r = 64'(prod[15:0]);
        5: r = 64'(prod[31:16]);
        7: r = x & y;
        default: r = x | y;
      endcase
      res = res | (r << (l*w));
    end
    return {1'b0, res};
  endfunction

  function automatic string tag_of(input int op, input int sz);
    logic [64:0] m;
    m = model(op, sz, 64'd0, 64'd0);
    if (m[64]) return "R9";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input int op, input int sz, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] m;
    string tag;
    m = model(op, sz, a, b);
    tag = tag_of(op, sz);
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'(op); in_size = 2'(sz); in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, "result", out_result, m[63:0]);
    check("R9", "err flag", {63'd0, out_err}, {63'd0, m[64]});
    check("R1", "valid after accept", {63'd0, out_valid}, 64'd1);
  endtask

  function automatic logic [63:0] corner(input int n);
    case (n)
      0: return 64'd0;
      1: return '1;
      2: return 64'h8080_8080_8080_8080;
      3: return 64'h7F7F_7F7F_7F7F_7F7F;
      4: return 64'h0001_0000_FFFF_8000;
      default: return 64'h00FF_FF00_7FFF_0001;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset valid", {63'd0, out_valid}, 64'd0);
    check("R10", "reset result", out_result, 64'd0);
    check("R10", "reset err", {63'd0, out_err}, 64'd0);
    rst_n = 1'b1;

    // boundary cases: carries must stop at lane edges (R2, R4)
    run_op(0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
    run_op(0, 1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
    run_op(2, 0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
    run_op(2, 2, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
    run_op(1, 0, 64'hFF80_7F01_FF80_7F01, 64'h0180_8001_0180_8001);
    run_op(3, 1, 64'h0001_8000_0005_FFFF, 64'h0002_7FFF_0005_0001);
    run_op(6, 1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    run_op(5, 1, 64'h8000_7FFF_FFFF_0002, 64'h8000_7FFF_0002_FFFF);

    // hold while idle (R1)
    @(negedge clk);
    check("R1", "valid drops when idle", {63'd0, out_valid}, 64'd0);
    check("R1", "result held when idle", out_result, model(5, 1, 64'h8000_7FFF_FFFF_0002,
          64'h8000_7FFF_0002_FFFF) & '1);

    // sweep every opcode and lane size
    for (int op = 0; op < 16; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        int nvec;
        nvec = (op <= 8 && sz < 3) ? 30 : 3;
        for (int n = 0; n < nvec; n++) begin
          logic [63:0] a, b;
          if (n < 6) begin
            a = corner(n);
            b = corner((n * 5 + 3) % 6);
          end else begin
            rng = next_rand(rng); a = rng;
            rng = next_rand(rng); b = rng;
          end
          run_op(op, sz, a, b);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule